// File: doc/BRIEF.md
# Banked Pin Controller with Masked Half-Word Writes

This block is a memory-mapped general-purpose I/O controller. It serves four banks of 32 pins each, and one bank is cut down to 22 pins. For every pin it keeps three bits: an output value, a direction and an output enable. From these it drives a per-pin output level and a per-pin drive enable toward the pad ring. It also samples the per-pin input levels through a two-flop synchronizer.

Software reaches the registers over a simple 32-bit bus. Each bus cycle carries a valid strobe, a write flag, a byte address and write data. The block answers one cycle later with a ready pulse and, for reads, the read data.

Each bank has two masked-write ports, one for each 16-bit half of the bank. A single bus write to one of these ports can set or clear any chosen subset of output bits in that half. The other bits of the half keep their value. This avoids a read-modify-write sequence and the race that comes with it.

Top module: `mbgpio`

## Requirements
- R1: While reset is asserted, and right after it is released, every output value, direction and enable bit is 0. As a result pinOut and pinOe are all 0, and the value, direction and enable registers read back 0.
- R2: For each pin, pinOe is high only when both its direction bit and its enable bit are 1. pinOut always carries the pin's output value bit. A direction bit of 0 marks an input, and direction 1 with enable 0 marks a tristated output.
- R3: Offset 0x000+8*b is the masked port for pins 0-15 of bank b, and offset 0x004+8*b is the masked port for pins 16-31. In a write to either port, bits 31:16 are a protect mask and bits 15:0 are data. A mask bit of 0 loads the matching output bit from the data bit. A mask bit of 1 leaves that output bit unchanged.
- R4: Offset 0x040+4*b holds the full 32-bit output value register of bank b, and it can be read and written.
- R5: Offset 0x060+4*b is read-only and returns the synchronized input levels of bank b. A read completed at the first clock edge that sees a new pin level still returns the old level. A read completed two edges later returns the new level.
- R6: Offset 0x204+0x40*b holds the direction register of bank b, and offset 0x208+0x40*b holds its enable register. Both can be read and written.
- R7: Pin n belongs to bank n>>5 at bit n&31. On the flat pin vectors, pin n is bit n.
- R8: In bank 1, bits 22-31 are not implemented. In every register of that bank, including the masked ports, these bits read 0 and ignore writes, and those pins are never driven.
- R9: Reads of an unmapped offset return 0, and writes to one change nothing. Any address whose bits 1:0 are not 00 counts as unmapped.
- R10: A read of a masked port returns the addressed half of the output value in bits 15:0, with bits 31:16 as 0.
- R11: Each cycle with busValid high is one access. busReady is high exactly in the following cycle. Read data and the effect of a write both appear at that same edge.
- R12: pinOut and pinOe change only after an accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busValid | input | 1 | Access request for this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 12 | Byte address of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid with busReady |
| busReady | output | 1 | Access completed |
| pinIn | input | 128 | Input levels, pin n at bit n |
| pinOut | output | 128 | Output levels, pin n at bit n |
| pinOe | output | 128 | Drive enables, pin n at bit n |

## Verification
The masked ports are exercised in three ways. A directed single-pin set and clear in each half tells the low port apart from the high port. A write with the mask fully set shows that protected bits survive. Random mask and data words then catch any inversion of the mask sense.

Writes to the full value register, the direction register and the enable register are interleaved at random, and the pin vectors are compared with a bench model after every write. This separates the input, tristate and driving states of a pin. Several further cases check address decoding and the short bank: writes across the 22-pin boundary of bank 1, writes to unmapped and misaligned offsets, and a read taken right after an input change, which shows the synchronizer depth.

// File: rtl/mbgpio_pkg.sv
package mbgpio_pkg;
  localparam int BANK_W     = 32;
  localparam int HALF_W     = BANK_W / 2;
  localparam int BANK_IDX_W = 3;
  localparam int MAX_BANKS  = 1 << BANK_IDX_W;

  typedef enum logic [2:0] {
    REG_NONE,
    REG_MASK_LO,
    REG_MASK_HI,
    REG_VALUE,
    REG_INPUT,
    REG_DIR,
    REG_ENA
  } regKind_e;

  typedef struct packed {
    logic                  wrStb;
    logic                  rdStb;
    regKind_e              kind;
    logic [BANK_IDX_W-1:0] bank;
  } gpioCmd_t;

  function automatic logic [BANK_W-1:0] bankImpl(input int b, input int shortBank,
                                                  input int shortPins);
    logic [BANK_W-1:0] m;
    for (int i = 0; i < BANK_W; i++) begin
      m[i] = (b != shortBank) || (i < shortPins);
    end
    return m;
  endfunction
endpackage

// File: rtl/mbgpio_ctrl.sv
module mbgpio_ctrl
  import mbgpio_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output gpioCmd_t          cmd,
  output logic              busReady
);
  localparam int MASK_END  = 8 * NUM_BANKS;
  localparam int VALUE_BEG = 'h40;
  localparam int INPUT_BEG = 'h60;
  localparam int CFG_PAGE  = 1;

  regKind_e              kind;
  logic [BANK_IDX_W-1:0] bankSel;
  int                    addrInt;

  always_comb begin
    addrInt = int'(busAddr);
    kind    = REG_NONE;
    bankSel = '0;
    if (addrInt < MASK_END) begin
      kind    = busAddr[2] ? REG_MASK_HI : REG_MASK_LO;
      bankSel = busAddr[5:3];
    end else if (addrInt >= VALUE_BEG && addrInt < VALUE_BEG + 4 * NUM_BANKS) begin
      kind    = REG_VALUE;
      bankSel = busAddr[4:2];
    end else if (addrInt >= INPUT_BEG && addrInt < INPUT_BEG + 4 * NUM_BANKS) begin
      kind    = REG_INPUT;
      bankSel = busAddr[4:2];
    end else if (int'(busAddr[ADDR_W-1:9]) == CFG_PAGE && int'(busAddr[8:6]) < NUM_BANKS) begin
      bankSel = busAddr[8:6];
      case (busAddr[5:0])
        6'h04:   kind = REG_DIR;
        6'h08:   kind = REG_ENA;
        default: kind = REG_NONE;
      endcase
    end
    if (busAddr[1:0] != 2'b00) kind = REG_NONE;
  end

  always_comb begin
    cmd.wrStb = busValid && busWrite && (kind != REG_NONE) && (kind != REG_INPUT);
    cmd.rdStb = busValid && !busWrite;
    cmd.kind  = kind;
    cmd.bank  = bankSel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busReady <= 1'b0;
    else       busReady <= busValid;
  end
endmodule

// File: rtl/mbgpio_dp.sv
module mbgpio_dp
  import mbgpio_pkg::*;
#(
  parameter int NUM_BANKS  = 4,
  parameter int SHORT_BANK = 1,
  parameter int SHORT_PINS = 22,
  localparam int PIN_CNT   = NUM_BANKS * BANK_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  gpioCmd_t           cmd,
  input  logic [BANK_W-1:0]  busWdata,
  input  logic [PIN_CNT-1:0] pinIn,
  output logic [BANK_W-1:0]  busRdata,
  output logic [PIN_CNT-1:0] pinOut,
  output logic [PIN_CNT-1:0] pinOe
);
  logic [BANK_W-1:0] valueArr [MAX_BANKS];
  logic [BANK_W-1:0] dirArr   [MAX_BANKS];
  logic [BANK_W-1:0] enaArr   [MAX_BANKS];
  logic [BANK_W-1:0] inArr    [MAX_BANKS];

  logic [HALF_W-1:0] wrMask, wrHalf;
  assign wrMask = busWdata[BANK_W-1:HALF_W];
  assign wrHalf = busWdata[HALF_W-1:0];

  for (genvar b = 0; b < MAX_BANKS; b++) begin : g_bank
    if (b < NUM_BANKS) begin : g_real
      localparam logic [BANK_W-1:0] IMPL = bankImpl(b, SHORT_BANK, SHORT_PINS);
      logic [BANK_W-1:0] valueQ, dirQ, enaQ, syncA, syncB, valueNext;
      logic              hit;

      assign hit = cmd.wrStb && (cmd.bank == BANK_IDX_W'(b));

      always_comb begin
        valueNext = valueQ;
        case (cmd.kind)
          REG_MASK_LO: valueNext[HALF_W-1:0] =
                         (valueQ[HALF_W-1:0] & wrMask) | (wrHalf & ~wrMask);
          REG_MASK_HI: valueNext[BANK_W-1:HALF_W] =
                         (valueQ[BANK_W-1:HALF_W] & wrMask) | (wrHalf & ~wrMask);
          REG_VALUE:   valueNext = busWdata;
          default:     valueNext = valueQ;
        endcase
      end

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          valueQ <= '0;
          dirQ   <= '0;
          enaQ   <= '0;
        end else if (hit) begin
          if (cmd.kind == REG_DIR)      dirQ   <= busWdata & IMPL;
          else if (cmd.kind == REG_ENA) enaQ   <= busWdata & IMPL;
          else                          valueQ <= valueNext & IMPL;
        end
      end

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          syncA <= '0;
          syncB <= '0;
        end else begin
          syncA <= pinIn[b*BANK_W +: BANK_W] & IMPL;
          syncB <= syncA;
        end
      end

      assign valueArr[b] = valueQ;
      assign dirArr[b]   = dirQ;
      assign enaArr[b]   = enaQ;
      assign inArr[b]    = syncB;
      assign pinOut[b*BANK_W +: BANK_W] = valueQ;
      assign pinOe[b*BANK_W +: BANK_W]  = dirQ & enaQ;
    end else begin : g_empty
      assign valueArr[b] = '0;
      assign dirArr[b]   = '0;
      assign enaArr[b]   = '0;
      assign inArr[b]    = '0;
    end
  end

  logic [BANK_W-1:0] rdNext, selValue;
  assign selValue = valueArr[cmd.bank];

  always_comb begin
    case (cmd.kind)
      REG_MASK_LO: rdNext = {{HALF_W{1'b0}}, selValue[HALF_W-1:0]};
      REG_MASK_HI: rdNext = {{HALF_W{1'b0}}, selValue[BANK_W-1:HALF_W]};
      REG_VALUE:   rdNext = selValue;
      REG_INPUT:   rdNext = inArr[cmd.bank];
      REG_DIR:     rdNext = dirArr[cmd.bank];
      REG_ENA:     rdNext = enaArr[cmd.bank];
      default:     rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          busRdata <= '0;
    else if (cmd.rdStb) busRdata <= rdNext;
    else                busRdata <= '0;
  end
endmodule

// File: rtl/mbgpio.sv
module mbgpio
  import mbgpio_pkg::*;
#(
  parameter int NUM_BANKS  = 4,
  parameter int SHORT_BANK = 1,
  parameter int SHORT_PINS = 22,
  parameter int ADDR_W     = 12,
  localparam int PIN_CNT   = NUM_BANKS * BANK_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busValid,
  input  logic               busWrite,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [BANK_W-1:0]  busWdata,
  output logic [BANK_W-1:0]  busRdata,
  output logic               busReady,
  input  logic [PIN_CNT-1:0] pinIn,
  output logic [PIN_CNT-1:0] pinOut,
  output logic [PIN_CNT-1:0] pinOe
);
  gpioCmd_t cmd;

  mbgpio_ctrl #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .cmd(cmd), .busReady(busReady)
  );

  mbgpio_dp #(.NUM_BANKS(NUM_BANKS), .SHORT_BANK(SHORT_BANK), .SHORT_PINS(SHORT_PINS)) dp_i (
    .clk(clk), .rstN(rstN), .cmd(cmd), .busWdata(busWdata), .pinIn(pinIn),
    .busRdata(busRdata), .pinOut(pinOut), .pinOe(pinOe)
  );
endmodule

// File: rtl/mbgpio_chk.sv
module mbgpio_chk #(
  parameter int NUM_BANKS  = 4,
  parameter int SHORT_BANK = 1,
  parameter int SHORT_PINS = 22,
  parameter int ADDR_W     = 12,
  localparam int PIN_CNT   = NUM_BANKS * 32
) (
  input logic               clk,
  input logic               rstN,
  input logic               busValid,
  input logic               busWrite,
  input logic [ADDR_W-1:0]  busAddr,
  input logic [31:0]        busWdata,
  input logic               busReady,
  input logic [PIN_CNT-1:0] pinOut,
  input logic [PIN_CNT-1:0] pinOe
);
  logic fullMaskWr;
  assign fullMaskWr = busValid && busWrite && (int'(busAddr) < 8 * NUM_BANKS) &&
                      (busAddr[1:0] == 2'b00) && (busWdata[31:16] == 16'hFFFF);

  a_r11_ready_follows: assert property (@(posedge clk) disable iff (!rstN)
    busValid |=> busReady);

  a_r11_no_spurious_ready: assert property (@(posedge clk) disable iff (!rstN)
    !busValid |=> !busReady);

  a_r12_pins_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(busValid && busWrite) |=> ($stable(pinOut) && $stable(pinOe)));

  a_r3_full_mask_keeps: assert property (@(posedge clk) disable iff (!rstN)
    fullMaskWr |=> ($stable(pinOut) && $stable(pinOe)));

  always @(negedge clk) begin
    if (!rstN) begin
      a_r1_reset_idle: assert (pinOut == '0 && pinOe == '0);
    end
  end

  if (SHORT_BANK < NUM_BANKS && SHORT_PINS < 32) begin : g_short
    always @(negedge clk) begin
      if (rstN) begin
        for (int i = SHORT_PINS; i < 32; i++) begin
          a_r8_short_quiet: assert (!pinOut[SHORT_BANK*32+i] && !pinOe[SHORT_BANK*32+i]);
        end
      end
    end
  end
endmodule

bind mbgpio mbgpio_chk #(
  .NUM_BANKS(NUM_BANKS), .SHORT_BANK(SHORT_BANK), .SHORT_PINS(SHORT_PINS), .ADDR_W(ADDR_W)
) chk_i (
  .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr),
  .busWdata(busWdata), .busReady(busReady), .pinOut(pinOut), .pinOe(pinOe)
);

// File: tb/mbgpio_tb_top.sv
module mbgpio_tb_top;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         busValid = 1'b0;
  logic         busWrite = 1'b0;
  logic [11:0]  busAddr = '0;
  logic [31:0]  busWdata = '0;
  logic [31:0]  busRdata;
  logic         busReady;
  logic [127:0] pinIn = '0;
  logic [127:0] pinOut, pinOe;

  int checks = 0;
  int fails = 0;
  bit ended = 1'b0;

  logic [31:0] mVal [4];
  logic [31:0] mDir [4];
  logic [31:0] mEna [4];

  always #2 clk = ~clk;

  mbgpio dut_i (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .busReady(busReady), .pinIn(pinIn),
    .pinOut(pinOut), .pinOe(pinOe)
  );

  function automatic logic [31:0] implM(input int b);
    return (b == 1) ? 32'h003F_FFFF : 32'hFFFF_FFFF;
  endfunction

  function automatic logic [127:0] expOut();
    return {mVal[3], mVal[2], mVal[1], mVal[0]};
  endfunction

  function automatic logic [127:0] expOe();
    return {mDir[3] & mEna[3], mDir[2] & mEna[2], mDir[1] & mEna[1], mDir[0] & mEna[0]};
  endfunction

  function automatic void applyWr(input logic [11:0] a, input logic [31:0] d);
    int ai = int'(a);
    int b;
    logic [15:0] m;
    if (a[1:0] != 2'b00) return;
    m = d[31:16];
    if (ai < 32) begin
      b = ai >> 3;
      if (a[2]) mVal[b][31:16] = (mVal[b][31:16] & m) | (d[15:0] & ~m);
      else      mVal[b][15:0]  = (mVal[b][15:0] & m) | (d[15:0] & ~m);
      mVal[b] &= implM(b);
    end else if (ai >= 'h40 && ai < 'h50) begin
      b = (ai - 'h40) >> 2;
      mVal[b] = d & implM(b);
    end else if (ai >= 'h200 && ai < 'h300) begin
      b = (ai - 'h200) >> 6;
      if ((ai & 'h3F) == 'h04) mDir[b] = d & implM(b);
      if ((ai & 'h3F) == 'h08) mEna[b] = d & implM(b);
    end
  endfunction

  function automatic logic [31:0] expRd(input logic [11:0] a);
    int ai = int'(a);
    int b;
    if (a[1:0] != 2'b00) return 32'h0;
    if (ai < 32) begin
      b = ai >> 3;
      return a[2] ? {16'h0, mVal[b][31:16]} : {16'h0, mVal[b][15:0]};
    end
    if (ai >= 'h40 && ai < 'h50) return mVal[(ai - 'h40) >> 2];
    if (ai >= 'h60 && ai < 'h70) begin
      b = (ai - 'h60) >> 2;
      return pinIn[b*32 +: 32] & implM(b);
    end
    if (ai >= 'h200 && ai < 'h300) begin
      b = (ai - 'h200) >> 6;
      if ((ai & 'h3F) == 'h04) return mDir[b];
      if ((ai & 'h3F) == 'h08) return mEna[b];
    end
    return 32'h0;
  endfunction

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [11:0] a, input logic [31:0] d,
                        output logic [31:0] rd);
    @(negedge clk);
    busValid = 1'b1;
    busWrite = wr;
    busAddr  = a;
    busWdata = d;
    @(negedge clk);
    busValid = 1'b0;
    busWrite = 1'b0;
    chk("R11 ready", {127'h0, busReady}, 128'h1);
    rd = busRdata;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    logic [31:0] dummy;
    access(1'b1, a, d, dummy);
    applyWr(a, d);
  endtask

  task automatic rdChk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] v;
    access(1'b0, a, 32'h0, v);
    chk(tag, {96'h0, v}, {96'h0, exp});
  endtask

  task automatic pinsChk(input string tag);
    chk({tag, " pinOut"}, pinOut, expOut());
    chk({tag, " pinOe"}, pinOe, expOe());
  endtask

  task automatic finishRun();
    if (!ended) begin
      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [31:0] v;
    logic [127:0] oldIn;
    void'($urandom(32'd20240611));
    for (int b = 0; b < 4; b++) begin
      mVal[b] = '0; mDir[b] = '0; mEna[b] = '0;
    end
    repeat (3) @(negedge clk);
    chk("R1 pins in reset", {pinOut, 1'b0} ^ {pinOe, 1'b0}, 128'h0);
    chk("R1 pinOe in reset", pinOe, 128'h0);
    rstN = 1'b1;
    @(negedge clk);
    pinsChk("R1 after reset");
    rdChk("R1 value reg", 12'h040, 32'h0);
    rdChk("R1 dir reg", 12'h204, 32'h0);
    rdChk("R1 ena reg", 12'h288, 32'h0);

    wr(12'h204, 32'h0000_000F);
    wr(12'h208, 32'h0000_0003);
    wr(12'h040, 32'h0000_000A);
    chk("R2 drive enable", {124'h0, pinOe[3:0]}, 128'h3);
    chk("R2 output value", {124'h0, pinOut[3:0]}, 128'hA);
    pinsChk("R2 model");
    rdChk("R6 dir readback", 12'h204, 32'h0000_000F);
    rdChk("R6 ena readback", 12'h208, 32'h0000_0003);

    wr(12'h04C, 32'h0000_0020);
    chk("R7 pin 101", {127'h0, pinOut[101]}, 128'h1);
    rdChk("R4 value readback", 12'h04C, 32'h0000_0020);

    wr(12'h010, 32'hFFFE_0001);
    chk("R3 low set bit", {127'h0, pinOut[64]}, 128'h1);
    wr(12'h014, 32'h7FFF_8000);
    chk("R3 high set bit", {127'h0, pinOut[95]}, 128'h1);
    rdChk("R3 value after masked", 12'h048, 32'h8000_0001);
    wr(12'h010, 32'hFFFE_0000);
    rdChk("R3 clear one bit", 12'h048, 32'h8000_0000);
    wr(12'h014, 32'hFFFF_0000);
    rdChk("R3 full mask holds", 12'h048, 32'h8000_0000);
    rdChk("R10 masked hi readback", 12'h014, 32'h0000_8000);
    rdChk("R10 masked lo readback", 12'h010, 32'h0000_0000);

    wr(12'h044, 32'hFFFF_FFFF);
    rdChk("R8 short value", 12'h044, 32'h003F_FFFF);
    wr(12'h00C, 32'h0000_FFFF);
    rdChk("R8 short masked hi", 12'h00C, 32'h0000_003F);
    wr(12'h244, 32'hFFFF_FFFF);
    wr(12'h248, 32'hFFFF_FFFF);
    chk("R8 short undriven", {118'h0, pinOe[63:54]}, 128'h0);
    chk("R8 short low", {106'h0, pinOut[53:32]}, {106'h0, 22'h3F_FFFF});
    pinsChk("R8 model");

    wr(12'h080, 32'hFFFF_FFFF);
    wr(12'h304, 32'hFFFF_FFFF);
    wr(12'h042, 32'h1234_5678);
    wr(12'h20C, 32'hFFFF_FFFF);
    pinsChk("R9 unmapped writes");
    rdChk("R9 unmapped read", 12'h080, 32'h0);
    rdChk("R9 misaligned read", 12'h042, 32'h0);

    oldIn = pinIn;
    @(negedge clk);
    pinIn = {$urandom, $urandom, $urandom, $urandom};
    access(1'b0, 12'h060, 32'h0, v);
    chk("R5 stale at first edge", {96'h0, v}, {96'h0, oldIn[31:0]});
    repeat (2) @(negedge clk);
    for (int b = 0; b < 4; b++) begin
      rdChk("R5 input bank", 12'h060 + 12'(4 * b), pinIn[b*32 +: 32] & implM(b));
    end

    for (int it = 0; it < 400; it++) begin
      int op = int'($urandom % 7);
      int b = int'($urandom % 4);
      logic [11:0] a;
      logic [31:0] d = $urandom;
      case (op)
        0: a = 12'(8 * b);
        1: a = 12'(8 * b + 4);
        2: a = 12'('h40 + 4 * b);
        3: a = 12'('h204 + 'h40 * b);
        4: a = 12'('h208 + 'h40 * b);
        5: a = 12'(8 * b + 4);
        default: a = 12'($urandom);
      endcase
      if (op == 5) d[31:16] = 16'hFFFF;
      wr(a, d);
      pinsChk("R12 random write");
      a = ($urandom % 2 == 0) ? 12'($urandom) : 12'(8 * b + 4 * int'($urandom % 2));
      rdChk("R4 random read", a, expRd(a));
    end

    finishRun();
  end
endmodule